// File: doc/BRIEF.md
# I2C Slave Address Detector

This block is the receive front end of an I2C slave. It samples the SCL and SDA lines with the system clock and recognises START and STOP conditions on any bus traffic. After each START it collects the seven address bits and the direction bit, and compares the address with a programmable own-address value.

When the address matches, the block acknowledges by pulling SDA low for the ninth clock. It also records the transfer direction, sets an addressed status bit and a sticky interrupt flag, and raises an interrupt output if interrupts are enabled. When the address does not match, it stays silent until the next START.

Software controls the block through a small write port with three selects. Select 0 is the control word, select 1 is the own address, and select 2 clears the interrupt flag. Status comes out as individual registered outputs. Data-byte transfer, clock stretching, general call, 10-bit addressing and bus time-out belong to other blocks.

Top module: `i2c_slave_addr_front`

## Requirements
- R1: While enabled, a START (SDA falls while SCL stays high) sets `busy_o`, whether or not this slave is addressed. A STOP (SDA rises while SCL stays high) clears `busy_o` and returns the frame logic to idle.
- R2: After a START, the block takes seven address bits on SCL rising edges, most significant bit first, and compares them with the own address.
- R3: The eighth bit after a START is the direction bit. On an address match it is stored in `rw_o` (1 = master reads and the slave transmits, 0 = master writes and the slave receives). On a mismatch, `rw_o` keeps its previous value.
- R4: On a match, `sda_drive_o` (1 = pull SDA low) turns on after the SCL falling edge that ends the eighth bit. It turns off after the SCL falling edge that ends the ninth bit. SDA therefore reads low during the high phase of the ninth clock.
- R5: On a match, `addressed_o` and `irq_flag_o` are set. `addressed_o` is cleared by the next START or STOP.
- R6: On a mismatch, the block does not drive SDA, leaves `addressed_o` at 0 and leaves `irq_flag_o` unchanged, and ignores the bus until the next START.
- R7: Control bit 0 (select 0) is the module enable. While it is 0, `busy_o`, `addressed_o` and `sda_drive_o` stay 0 and bus activity has no effect.
- R8: Control bit 1 (select 0) is the interrupt enable. `irq_o` is a registered copy of `irq_flag_o` AND the interrupt enable.
- R9: The own address (select 1, data bits 6..0) can be written only while the module enable is 0. A write at any other time is ignored. The current value is visible on `own_addr_o`.
- R10: Writing to select 2 with data bit 0 set to 1 clears `irq_flag_o`.
- R11: A START in the middle of a frame restarts address collection at the first bit, and `busy_o` stays 1.
- R12: SCL and SDA pass through a two-flop synchronizer before use. After reset, all status outputs, `sda_drive_o`, both enables and the own address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_drive_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 control, 1 own address, 2 flag clear |
| wr_data_i | input | 8 | Write data |
| own_addr_o | output | 7 | Current own address |
| busy_o | output | 1 | Bus-busy status |
| addressed_o | output | 1 | Addressed-as-slave status |
| rw_o | output | 1 | Latched direction bit |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Interrupt request, gated by the interrupt enable |

## Verification
The bench sends the bit-reversed form of the own address. A design that shifts least-significant bit first would acknowledge that frame.

It issues a repeated START after three leftover bits. Without a bit-counter restart, the following correct address would be misread and not acknowledged.

It writes the own address while the module is enabled, runs traffic while the module is disabled, and disables the module in the middle of a frame. A design without the write lock or the idle hold would change the address or set status bits in those cases.

It watches the wired SDA line during the ninth clock of both matching and non-matching frames. This catches an acknowledge that is missing, sent in the wrong clock, or sent for a foreign address.

// File: rtl/i2c_sad_pkg.sv
package i2c_sad_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK_DRV,
    ST_WAIT
  } frame_st_t;

  localparam int          SEL_W        = 2;
  localparam logic [1:0]  SEL_CTRL     = 2'd0;
  localparam logic [1:0]  SEL_OWN      = 2'd1;
  localparam logic [1:0]  SEL_CLR      = 2'd2;
  localparam int          CTRL_EN_BIT  = 0;
  localparam int          CTRL_IE_BIT  = 1;
  localparam int          CLR_FLAG_BIT = 0;
endpackage

// File: rtl/i2c_sad_sync.sv
module i2c_sad_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_sad_cond.sv
module i2c_sad_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_sad_fsm.sv
module i2c_sad_fsm
  import i2c_sad_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_s_i,
  output logic              busy_o,
  output logic              addressed_o,
  output logic              rw_o,
  output logic              sda_drive_o,
  output logic              match_o
);
  localparam int              CNT_W    = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W);

  frame_st_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] shift_q;
  logic              busy_q, addressed_q, rw_q, drive_q;
  logic              last_edge, addr_hit;

  assign last_edge = (state_q == ST_ADDR) && scl_rise_i && (cnt_q == LAST_BIT);
  assign addr_hit  = (shift_q == own_addr_i);
  assign match_o   = en_i && !start_i && !stop_i && last_edge && addr_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      shift_q     <= '0;
      busy_q      <= 1'b0;
      addressed_q <= 1'b0;
      rw_q        <= 1'b0;
      drive_q     <= 1'b0;
    end else if (!en_i) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      busy_q      <= 1'b0;
      addressed_q <= 1'b0;
      drive_q     <= 1'b0;
    end else if (stop_i) begin
      state_q     <= ST_IDLE;
      busy_q      <= 1'b0;
      addressed_q <= 1'b0;
      drive_q     <= 1'b0;
    end else if (start_i) begin
      state_q     <= ST_ADDR;
      cnt_q       <= '0;
      busy_q      <= 1'b1;
      addressed_q <= 1'b0;
      drive_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            if (cnt_q == LAST_BIT) begin
              if (addr_hit) begin
                addressed_q <= 1'b1;
                rw_q        <= sda_s_i;
                state_q     <= ST_ACK_WAIT;
              end else begin
                state_q     <= ST_WAIT;
              end
            end else begin
              shift_q <= {shift_q[ADDR_W-2:0], sda_s_i};
              cnt_q   <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_ACK_WAIT: begin
          if (scl_fall_i) begin
            drive_q <= 1'b1;
            state_q <= ST_ACK_DRV;
          end
        end
        ST_ACK_DRV: begin
          if (scl_fall_i) begin
            drive_q <= 1'b0;
            state_q <= ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy_o      = busy_q;
  assign addressed_o = addressed_q;
  assign rw_o        = rw_q;
  assign sda_drive_o = drive_q;

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!busy_q && !addressed_q && !drive_q)); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (en_i && start_i) |=> busy_q); // R1
  AST_STOP_FREE: assert property (@(posedge clk) disable iff (rst)
    (en_i && stop_i) |=> !busy_q); // R1
  AST_DRIVE_ADDRESSED: assert property (@(posedge clk) disable iff (rst)
    drive_q |-> addressed_q); // R4
  AST_RESTART_BUSY: assert property (@(posedge clk) disable iff (rst)
    (en_i && start_i && busy_q) |=> (busy_q && !addressed_q)); // R11
endmodule

// File: rtl/i2c_sad_regs.sv
module i2c_sad_regs
  import i2c_sad_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              set_flag_i,
  output logic              en_o,
  output logic [ADDR_W-1:0] own_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic              en_q, ie_q, flag_q, irq_q;
  logic [ADDR_W-1:0] own_q;
  logic              ctrl_wr, own_wr, clr_wr;
  logic              flag_next, ie_next;
  logic              unused_data;

  assign unused_data = ^wr_data_i;
  assign ctrl_wr   = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign own_wr    = wr_en_i && (wr_sel_i == SEL_OWN) && !en_q;
  assign clr_wr    = wr_en_i && (wr_sel_i == SEL_CLR) && wr_data_i[CLR_FLAG_BIT];
  assign ie_next   = ctrl_wr ? wr_data_i[CTRL_IE_BIT] : ie_q;
  assign flag_next = set_flag_i ? 1'b1 : (clr_wr ? 1'b0 : flag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      own_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) en_q <= wr_data_i[CTRL_EN_BIT];
      ie_q   <= ie_next;
      if (own_wr) own_q <= wr_data_i[ADDR_W-1:0];
      flag_q <= flag_next;
      irq_q  <= flag_next & ie_next;
    end
  end

  assign en_o   = en_q;
  assign own_o  = own_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  AST_OWN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    en_q |=> $stable(own_q)); // R9
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    set_flag_i |=> flag_q); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!ie_q && !ctrl_wr) |=> !irq_q); // R8
  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !set_flag_i) |=> !flag_q); // R10
endmodule

// File: rtl/i2c_slave_addr_front.sv
module i2c_slave_addr_front
  import i2c_sad_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_o,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] own_addr_o,
  output logic              busy_o,
  output logic              addressed_o,
  output logic              rw_o,
  output logic              irq_flag_o,
  output logic              irq_o
);
  logic [1:0]        line_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              en, match;
  logic [ADDR_W-1:0] own;

  i2c_sad_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o (line_s)
  );

  i2c_sad_cond u_cond (
    .clk        (clk),
    .rst        (rst),
    .scl_s_i    (line_s[1]),
    .sda_s_i    (line_s[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_sad_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en),
    .own_addr_i  (own),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .sda_s_i     (line_s[0]),
    .busy_o      (busy_o),
    .addressed_o (addressed_o),
    .rw_o        (rw_o),
    .sda_drive_o (sda_drive_o),
    .match_o     (match)
  );

  i2c_sad_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .set_flag_i (match),
    .en_o       (en),
    .own_o      (own),
    .flag_o     (irq_flag_o),
    .irq_o      (irq_o)
  );

  assign own_addr_o = own;

  AST_MATCH_ACTS: assert property (@(posedge clk) disable iff (rst)
    match |=> (addressed_o && irq_flag_o)); // R5
endmodule

// File: tb/i2c_slave_addr_front_tb_top.sv
module i2c_slave_addr_front_tb_top;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_line;
  logic       sda_drive;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] own_addr;
  logic       busy, addressed, rw, irq_flag, irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_drive;

  i2c_slave_addr_front dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_drive_o(sda_drive),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .own_addr_o(own_addr),
    .busy_o(busy), .addressed_o(addressed), .rw_o(rw), .irq_flag_o(irq_flag), .irq_o(irq)
  );

  // behavioural reference model
  bit scl_h[$], sda_h[$];
  int m_state, m_cnt, m_sh, m_own;
  bit m_busy, m_adr, m_rw, m_drv, m_en, m_ie, m_flag, m_irq;

  always @(posedge clk) begin
    if (rst) begin
      scl_h = '{1, 1, 1, 1}; sda_h = '{1, 1, 1, 1};
      m_state = 0; m_cnt = 0; m_sh = 0; m_own = 0;
      m_busy = 0; m_adr = 0; m_rw = 0; m_drv = 0;
      m_en = 0; m_ie = 0; m_flag = 0; m_irq = 0;
    end else begin
      bit s, q, ds, dq, rise, fall, st, sp, en_old, hit;
      scl_h.push_front(scl_m);
      sda_h.push_front(sda_m & ~m_drv);
      while (scl_h.size() > 4) void'(scl_h.pop_back());
      while (sda_h.size() > 4) void'(sda_h.pop_back());
      s = scl_h[2]; q = scl_h[3]; ds = sda_h[2]; dq = sda_h[3];
      rise = s && !q; fall = !s && q;
      st = s && q && dq && !ds; sp = s && q && !dq && ds;
      en_old = m_en; hit = 0;
      if (!en_old) begin
        m_state = 0; m_cnt = 0; m_busy = 0; m_adr = 0; m_drv = 0;
      end else if (sp) begin
        m_state = 0; m_busy = 0; m_adr = 0; m_drv = 0;
      end else if (st) begin
        m_state = 1; m_cnt = 0; m_busy = 1; m_adr = 0; m_drv = 0;
      end else if (m_state == 1 && rise) begin
        if (m_cnt == 7) begin
          if (m_sh == m_own) begin
            hit = 1; m_adr = 1; m_rw = ds; m_state = 2;
          end else m_state = 4;
        end else begin
          m_sh = ((m_sh << 1) | int'(ds)) & 8'h7f; m_cnt++;
        end
      end else if (m_state == 2 && fall) begin
        m_drv = 1; m_state = 3;
      end else if (m_state == 3 && fall) begin
        m_drv = 0; m_state = 4;
      end
      if (wr_en) begin
        if (wr_sel == 2'd0) begin m_en = wr_data[0]; m_ie = wr_data[1]; end
        else if (wr_sel == 2'd1 && !en_old) m_own = int'(wr_data[6:0]);
        else if (wr_sel == 2'd2 && wr_data[0]) m_flag = 0;
      end
      if (hit) m_flag = 1;
      m_irq = m_flag && m_ie;
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      cmp("R1",  "model busy",      busy,      m_busy);
      cmp("R5",  "model addressed", addressed, m_adr);
      cmp("R3",  "model rw",        rw,        m_rw);
      cmp("R10", "model flag",      irq_flag,  m_flag);
      cmp("R8",  "model irq",       irq,       m_irq);
      cmp("R4",  "model drive",     sda_drive, m_drv);
      cmp("R9",  "model own",       own_addr,  m_own);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(logic [1:0] sel, logic [7:0] data);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = data;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_start();
    tick(2); sda_m = 1; tick(HALF); scl_m = 1; tick(HALF); sda_m = 0; tick(HALF); scl_m = 0;
  endtask

  task automatic bus_stop();
    tick(2); sda_m = 0; tick(HALF); scl_m = 1; tick(HALF); sda_m = 1; tick(HALF);
  endtask

  task automatic send_bit(bit b);
    tick(2); sda_m = b; tick(HALF); scl_m = 1; tick(HALF); scl_m = 0;
  endtask

  task automatic ack_bit(output bit line_low);
    tick(2); sda_m = 1; tick(HALF); scl_m = 1; tick(HALF / 2);
    line_low = !sda_line; tick(HALF / 2); scl_m = 0;
  endtask

  task automatic send_addr(logic [6:0] a, bit dir, output bit acked);
    for (int i = 6; i >= 0; i--) send_bit(a[i]);
    send_bit(dir);
    ack_bit(acked);
  endtask

  initial begin
    bit ak;
    tick(5); rst = 0; tick(3);
    // R12 reset state
    cmp("R12", "reset busy", busy, 0);
    cmp("R12", "reset addressed/flag/irq/drive", {addressed, irq_flag, irq, sda_drive}, 0);
    cmp("R12", "reset own", own_addr, 0);
    // R7 disabled: own address 0 frame must do nothing
    bus_start(); tick(4);
    cmp("R7", "busy while disabled", busy, 0);
    send_addr(7'h00, 0, ak);
    cmp("R7", "ack while disabled", ak, 0);
    cmp("R7", "addressed while disabled", addressed, 0);
    bus_stop();
    // R9 write own address while disabled, then try while enabled
    reg_wr(2'd1, 8'h5A); tick(2);
    cmp("R9", "own written while off", own_addr, 7'h5A);
    reg_wr(2'd0, 8'h03);
    reg_wr(2'd1, 8'h11); tick(2);
    cmp("R9", "own locked while on", own_addr, 7'h5A);
    // R1 start sets busy; R2..R5 matching write frame
    bus_start(); tick(4);
    cmp("R1", "busy after start", busy, 1);
    send_addr(7'h5A, 0, ak);
    cmp("R4", "ack on 9th clock", ak, 1);
    tick(4);
    cmp("R5", "addressed after match", addressed, 1);
    cmp("R5", "flag after match", irq_flag, 1);
    cmp("R8", "irq enabled", irq, 1);
    cmp("R3", "rw write", rw, 0);
    cmp("R4", "drive released after 9th", sda_drive, 0);
    bus_stop(); tick(4);
    cmp("R1", "busy after stop", busy, 0);
    cmp("R5", "addressed after stop", addressed, 0);
    reg_wr(2'd2, 8'h01); tick(2);
    cmp("R10", "flag cleared", irq_flag, 0);
    cmp("R10", "irq cleared", irq, 0);
    // R6 mismatch, read direction
    bus_start(); send_addr(7'h5B, 1, ak); tick(4);
    cmp("R6", "no ack on mismatch", ak, 0);
    cmp("R6", "flag untouched", irq_flag, 0);
    cmp("R6", "not addressed", addressed, 0);
    cmp("R3", "rw kept on mismatch", rw, 0);
    cmp("R1", "busy on foreign frame", busy, 1);
    bus_stop();
    // R2 bit-reversed address must not match
    bus_start(); send_addr(7'h2D, 0, ak);
    cmp("R2", "msb-first compare", ak, 0);
    bus_stop();
    // R3 read direction on match
    bus_start(); send_addr(7'h5A, 1, ak); tick(4);
    cmp("R3", "rw read", rw, 1);
    bus_stop();
    reg_wr(2'd2, 8'h01);
    // R8 interrupt masked
    reg_wr(2'd0, 8'h01);
    bus_start(); send_addr(7'h5A, 0, ak); tick(4);
    cmp("R8", "flag set while masked", irq_flag, 1);
    cmp("R8", "irq masked", irq, 0);
    bus_stop();
    reg_wr(2'd2, 8'h01);
    // R11 repeated start mid-frame
    bus_start(); send_bit(1); send_bit(1); send_bit(0);
    bus_start(); tick(4);
    cmp("R11", "busy kept on restart", busy, 1);
    send_addr(7'h5A, 0, ak);
    cmp("R11", "ack after restart", ak, 1);
    bus_stop();
    // R7 disable mid-frame
    bus_start(); send_bit(1); tick(2);
    reg_wr(2'd0, 8'h00); tick(3);
    cmp("R7", "busy cleared on disable", busy, 0);
    bus_stop(); tick(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule